// File: doc/BRIEF.md
# Pin-Change Interrupt Controller

This block watches the synchronized input levels of a 16-pin expander, arranged as two 8-pin ports, and pulls a single active-low interrupt line whenever an enabled input pin has moved away from the level the host last saw. Rising and falling moves both count, so releasing an input is reported in the same way as pressing it. For every port the block holds a snapshot of the pin levels. The snapshot is taken at reset and again each time the host reads that port's input-state register.

A pin is enabled when it is configured as a GPIO input and its interrupt-disable bit is 0. A change must be seen on two consecutive synchronized samples before it counts, so a one-cycle glitch is dropped. Once a pin is flagged, it stays pending until the host reads its port. That read clears every pending flag of the port and reloads the port's snapshot from the current levels. The host then works out which pins moved by comparing the value it reads with the value it read before.

Top module: `pcint_ctrl`

## Requirements
- R1: In the clock cycle after any clock edge with `rst_n` low, `irq_n` is 1. Reset loads the snapshot from the current pin levels, so no interrupt follows reset whatever those levels are.
- R2: Pin i is enabled when `pin_in_mode[i]` is 1 (GPIO input) and `irq_dis[i]` is 0. If an enabled pin rises above its snapshot level and holds, `irq_n` stays 1 after the first clock edge that samples the new level and goes 0 after the second.
- R3: A falling change on an enabled pin asserts `irq_n` with the same two-edge timing as R2.
- R4: A level that differs from the snapshot on only one sample and then returns to the snapshot level never asserts `irq_n`.
- R5: A pin with `irq_dis[i]` = 1 never raises a pending flag, whatever its level does.
- R6: A pin with `pin_in_mode[i]` = 0 (output or PWM) never raises a pending flag.
- R7: Once `irq_n` is 0 it stays 0 until the host reads the port that holds the pending pin. Port p holds pins p*8 to p*8+7. A read is `port_rd[p]` = 1 for one clock edge, and it clears that port's pending flags at that edge. A read of the other port leaves them set.
- R8: A port read reloads that port's snapshot with the current levels. A pin that stays at its new level raises nothing more, and a later return to the old level is a new change.
- R9: A pending flag asserts `irq_n` only while its pin is enabled. Setting the disable bit of a pending pin releases `irq_n` without clearing the flag, and clearing the disable bit again asserts `irq_n` with no new change on the pin.
- R10: `irq_n` is the active-low OR of the pending pins of both ports. With pins pending in both ports, `irq_n` stays 0 until both ports have been read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | 16 | Synchronized pin levels, bit i = pin i |
| pin_in_mode | input | 16 | 1 = pin is a GPIO input, 0 = output or PWM |
| irq_dis | input | 16 | Per-pin interrupt disable, 1 = suppressed |
| port_rd | input | 2 | One-cycle strobe, host reads the input register of port p |
| irq_n | output | 1 | Active-low combined interrupt |

## Verification
Some properties are checked at every clock edge. A newly raised pending flag must come from an enabled pin whose level was stable over the two samples before it. A port read must leave that port with no pending flag. `irq_n` is never low unless some pending flag is set, and it is high after every reset edge. The end-to-end behaviour is shown only by the bench's scenarios, which sweep every pin in both directions. These cover the exact two-edge latency, snapshot reload and re-arming after a read, release and reassertion through the disable bit, and the independence of the two ports' reads.

// File: rtl/pcint_pkg.sv
// Package: shared sizing helpers for the pin-change interrupt controller.
// Assumes every port has the same number of pins.
package pcint_pkg;

    localparam int unsigned PORTS_DEF = 2;
    localparam int unsigned PORT_W_DEF = 8;

    // Total pin count across all ports.
    function automatic int unsigned pins_total(input int unsigned ports,
                                               input int unsigned width);
        return ports * width;
    endfunction

endpackage

// File: rtl/pcint_port.sv
// Module: per-port change detector.
// Keeps the host-visible snapshot, a one-sample delay for glitch filtering
// and the sticky pending flags of one port. Assumes lvl is already
// synchronized to clk. rd clears pending and reloads the snapshot.
module pcint_port #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] dis,
    input  logic [W-1:0] is_in,
    input  logic         rd,
    output logic [W-1:0] pend,
    output logic         req
);

    logic [W-1:0] lvl_q;
    logic [W-1:0] snap_q;
    logic [W-1:0] pend_q;
    logic [W-1:0] en;
    logic [W-1:0] evt;

    // Enable per pin: a GPIO input whose disable bit is clear.
    assign en  = ~dis & is_in;
    // Event: level held for two samples and different from the snapshot.
    assign evt = en & ~(lvl ^ lvl_q) & (lvl ^ snap_q);

    // Previous sample of the pin levels, used by the persistence filter.
    always_ff @(posedge clk) begin
        lvl_q <= lvl;
    end

    // Snapshot, loaded at reset and on each host read of this port.
    always_ff @(posedge clk) begin
        if (!rst_n || rd) begin
            snap_q <= lvl;
        end
    end

    // Sticky pending flags, cleared by reset or a host read.
    always_ff @(posedge clk) begin
        if (!rst_n || rd) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_q | evt;
        end
    end

    assign pend = pend_q;
    // Port request: any pending pin that is still enabled.
    assign req  = |(pend_q & en);

endmodule

// File: rtl/pcint_merge.sv
// Module: combines the per-port requests into one active-low line.
// Assumes the requests are active high.
module pcint_merge #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] req,
    output logic         irq_n
);

    // Active-low wired-OR of all port requests.
    assign irq_n = ~(|req);

endmodule

// File: rtl/pcint_ctrl.sv
// Module: pin-change interrupt controller top.
// One detector per port, generated from the port count, feeding a single
// active-low interrupt. Assumes synchronized inputs, one-cycle read strobes
// and pin i of port p at vector index p*PORT_W+i.
module pcint_ctrl
    import pcint_pkg::*;
#(
    parameter int unsigned NUM_PORTS = PORTS_DEF,
    parameter int unsigned PORT_W    = PORT_W_DEF,
    localparam int unsigned PIN_N    = pins_total(NUM_PORTS, PORT_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_N-1:0]     pin_lvl,
    input  logic [PIN_N-1:0]     pin_in_mode,
    input  logic [PIN_N-1:0]     irq_dis,
    input  logic [NUM_PORTS-1:0] port_rd,
    output logic                 irq_n
);

    logic [PIN_N-1:0]     pend_all;
    logic [NUM_PORTS-1:0] port_req;

    // One change detector per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pcint_port #(.W(PORT_W)) u_port (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (pin_lvl[p*PORT_W +: PORT_W]),
            .dis   (irq_dis[p*PORT_W +: PORT_W]),
            .is_in (pin_in_mode[p*PORT_W +: PORT_W]),
            .rd    (port_rd[p]),
            .pend  (pend_all[p*PORT_W +: PORT_W]),
            .req   (port_req[p])
        );
    end

    // Combine the port requests onto the interrupt line.
    pcint_merge #(.N(NUM_PORTS)) u_merge (
        .req   (port_req),
        .irq_n (irq_n)
    );

endmodule

// File: rtl/pcint_ctrl_chk.sv
// Module: assertion checker for pcint_ctrl, attached by bind.
// Observes ports and the pending flags the detectors drive.
module pcint_ctrl_chk #(
    parameter int unsigned PIN_N     = 16,
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned PORT_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [PIN_N-1:0]     pin_lvl,
    input logic [PIN_N-1:0]     pin_in_mode,
    input logic [PIN_N-1:0]     irq_dis,
    input logic [NUM_PORTS-1:0] port_rd,
    input logic [PIN_N-1:0]     pend,
    input logic                 irq_n
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> irq_n);

    // R4
    stable_before_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend)) & ($past(pin_lvl) ^ $past(pin_lvl, 2))) == '0);

    // R5
    disabled_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend)) & $past(irq_dis)) == '0);

    // R6
    non_input_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend)) & ~$past(pin_in_mode)) == '0);

    // R10
    irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (pend != '0));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        // R7
        read_clears_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
            port_rd[p] |=> (pend[p*PORT_W +: PORT_W] == '0));
    end

endmodule

bind pcint_ctrl pcint_ctrl_chk #(
    .PIN_N     (PIN_N),
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_lvl     (pin_lvl),
    .pin_in_mode (pin_in_mode),
    .irq_dis     (irq_dis),
    .port_rd     (port_rd),
    .pend        (pend_all),
    .irq_n       (irq_n)
);

// File: tb/test_pcint_ctrl.sv
`timescale 1ns/1ps
// Bench: sweeps every pin through disabled, non-input and enabled changes
// in both directions, plus glitch, gating, dual-port and reset scenarios.
module test_pcint_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lvl = 16'hA5C3;
    logic [15:0] dir = 16'hFFFF;
    logic [15:0] dis = 16'h0000;
    logic [1:0]  rd = 2'b00;
    logic        irq_n;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcint_ctrl i_pcint_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_lvl     (lvl),
        .pin_in_mode (dir),
        .irq_dis     (dis),
        .port_rd     (rd),
        .irq_n       (irq_n)
    );

    // Advance one edge and settle away from it.
    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input logic exp, input string tag);
        nchk++;
        if (irq_n !== exp) begin
            nfail++;
            $display("FAIL %s irq_n=%0b expected=%0b at %0t", tag, irq_n, exp, $time);
        end
    endtask

    task automatic rd_port(input int p);
        rd[p] = 1'b1;
        step();
        rd = 2'b00;
    endtask

    initial begin
        // R1: reset with mixed levels, no interrupt afterwards
        step(3);
        chk(1'b1, "R1 during reset");
        rst_n = 1'b1;
        step(3);
        chk(1'b1, "R1 after reset");

        // R4: one-sample glitch on pin 0
        lvl[0] = ~lvl[0];
        step();
        lvl[0] = ~lvl[0];
        step(3);
        chk(1'b1, "R4 glitch ignored");

        // Sweep every pin, two passes so each pin rises and falls
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 16; i++) begin
                int p;
                int q;
                p = i / 8;
                q = 1 - p;
                // R5: disabled pin
                dis[i] = 1'b1;
                lvl[i] = ~lvl[i];
                step(3);
                chk(1'b1, "R5 disabled pin");
                lvl[i] = ~lvl[i];
                step(2);
                dis[i] = 1'b0;
                step();
                chk(1'b1, "R5 re-enable clean");
                // R6: pin not an input
                dir[i] = 1'b0;
                lvl[i] = ~lvl[i];
                step(3);
                chk(1'b1, "R6 non-input pin");
                lvl[i] = ~lvl[i];
                step(2);
                dir[i] = 1'b1;
                step();
                chk(1'b1, "R6 back to input clean");
                // R2 / R3: enabled change, two-edge latency
                lvl[i] = ~lvl[i];
                step();
                chk(1'b1, "R2/R3 first sample");
                step();
                chk(1'b0, lvl[i] ? "R2 rising" : "R3 falling");
                step(3);
                chk(1'b0, "R7 held");
                rd_port(q);
                chk(1'b0, "R7 other port read");
                rd_port(p);
                chk(1'b1, "R7 own port read");
                step(3);
                chk(1'b1, "R8 snapshot reloaded");
            end
        end

        // R8: return to old level after a read is a new change
        lvl[6] = ~lvl[6];
        step(2);
        rd_port(0);
        lvl[6] = ~lvl[6];
        step(2);
        chk(1'b0, "R8 return is new change");
        rd_port(0);
        chk(1'b1, "R8 cleared");

        // R9: disable gates a pending flag without clearing it
        lvl[5] = ~lvl[5];
        step(2);
        chk(1'b0, "R9 pending");
        dis[5] = 1'b1;
        step();
        chk(1'b1, "R9 gated off");
        dis[5] = 1'b0;
        step();
        chk(1'b0, "R9 reasserted");
        rd_port(0);
        chk(1'b1, "R9 cleared");

        // R10: pending in both ports
        lvl[2] = ~lvl[2];
        lvl[9] = ~lvl[9];
        step(2);
        chk(1'b0, "R10 both pending");
        rd_port(0);
        chk(1'b0, "R10 port1 still pending");
        rd_port(1);
        chk(1'b1, "R10 all cleared");

        // R1: reset clears a pending flag and reloads the snapshot
        lvl[4] = ~lvl[4];
        step(2);
        chk(1'b0, "R1 pending before reset");
        lvl[11] = ~lvl[11];
        rst_n = 1'b0;
        step(2);
        chk(1'b1, "R1 reset drops irq");
        rst_n = 1'b1;
        step(3);
        chk(1'b1, "R1 no irq after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule